// File: doc/BRIEF.md
# SEC-DED Protected RAM with Scrub Writeback

A single-clock memory of 512 words in which every stored word carries a 64-bit payload, seven Hamming check bits and one overall even-parity bit. The write port encodes the payload before it is stored. The read port has its own address. It checks the stored word, repairs a single flipped bit in the data it returns, and raises one of two flags: corrected single error or detected double error. When a double error is seen, the data goes out as stored and no bit is flipped.

Correction fixes only the returned data, so the stored word stays wrong. An optional scrub path can be turned on at run time. When it is on, each corrected read re-encodes the repaired payload and writes it back to the same address on a cycle when the user write port is idle. A user write always takes precedence. A user write to the same address discards the pending scrub. Two saturating 16-bit counters tally corrected and double-error reads, and each counter has a synchronous clear. A per-bit inversion mask on the write port lets a stored word be built with chosen bits flipped, so that errors can be placed on purpose.

Top module: `ecc_ram_scrub`

## Requirements
- R1: Stored word layout: bit 0 is even parity over bits 71..1; bit p (1..71) holds codeword position p. Check bits sit at positions 1, 2, 4, 8, 16, 32 and 64. Data bit i occupies the (i+1)-th position that is not a power of two, counting upward, so data bit 0 is at position 3 and data bit 63 is at position 71. wr_flip_i is XORed into the stored word in this same indexing.
- R2: A read issued with rd_en_i at a rising edge presents rd_valid_o, rd_data_o, sec_o and ded_o during the following cycle. While rd_valid_o is low, rd_data_o is zero and both flags are low.
- R3: If exactly one bit at positions 1..71 of the stored word is inverted, the read returns the written payload with sec_o=1 and ded_o=0.
- R4: If exactly two bits of the stored word are inverted, the read gives ded_o=1 and sec_o=0, and the payload is returned with its stored (flipped) data bits left as they are.
- R5: If only the parity bit (bit 0) is inverted, the read gives sec_o=1 and ded_o=0, and the payload is returned unchanged.
- R6: With scrub_en_i high, a corrected read causes the repaired word to be written back, so a read of that address issued four or more cycles after the flagged result is clean. With scrub_en_i low, the stored word is not touched and a later read is flagged again.
- R7: A user write to the scrubbed address, issued in either of the two cycles after the flagged result, replaces the scrub: a later read returns the user data with no flag. A user write to a different address delays the scrub but does not cancel it.
- R8: sec_cnt_o and ded_cnt_o each add one per read result that shows the matching flag, and they stop at 65535. A flag of one class does not change the other counter.
- R9: clr_sec_cnt_i or clr_ded_cnt_i zeroes its own counter at the next edge. A clear takes priority over an increment in the same cycle and leaves the other counter unchanged.
- R10: During reset, rd_valid_o, sec_o and ded_o are low, and rd_data_o and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | User write strobe |
| wr_addr_i | input | 9 | User write address |
| wr_data_i | input | 64 | User write payload |
| wr_flip_i | input | 72 | Bits to invert in the stored word (error placement) |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 9 | Read address |
| scrub_en_i | input | 1 | Enables writeback of corrected words |
| clr_sec_cnt_i | input | 1 | Synchronous clear of the corrected-error counter |
| clr_ded_cnt_i | input | 1 | Synchronous clear of the double-error counter |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 64 | Corrected read payload |
| sec_o | output | 1 | Single error corrected |
| ded_o | output | 1 | Double error detected |
| sec_cnt_o | output | 16 | Saturating count of corrected reads |
| ded_cnt_o | output | 16 | Saturating count of double-error reads |

## Verification
The assertions assume that all addresses are below the depth, that every read targets a word that has been written, and that a stored word never holds more than two inverted bits. Reads of unwritten words would return unknown values, and triple errors would fall outside the single-error-correct, double-error-detect classes. The stimulus writes every location before it reads it, keeps all addresses inside the 512 entries, and builds each wr_flip_i mask with at most two set bits. It also never reads an address in the same cycle that the address is written.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;
  localparam int MAX_POS = 255;

  // smallest h with d + h + 1 <= 2^h
  function automatic int calc_chk_w(int data_w);
    int h;
    h = 1;
    while ((data_w + h + 1) > (1 << h)) h++;
    return h;
  endfunction

  function automatic bit is_pow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // positions whose index has bit k set
  function automatic logic [MAX_POS:0] cover_mask(int npos, int k);
    logic [MAX_POS:0] m;
    m = '0;
    for (int p = 1; p <= npos; p++)
      if (((p >> k) & 1) == 1) m[p] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_ram_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = calc_chk_w(DATA_W),
  localparam int NPOS  = DATA_W + CHK_W,
  localparam int CW_W  = NPOS + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  logic [NPOS:1]    plain;
  logic [CHK_W-1:0] chk;

  always_comb begin
    int di;
    di    = 0;
    plain = '0;
    for (int p = 1; p <= NPOS; p++) begin
      if (!is_pow2(p)) begin
        plain[p] = data_i[di];
        di++;
      end
    end
  end

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [MAX_POS:0] FULL = cover_mask(NPOS, k);
    localparam logic [NPOS:1]    MASK = FULL[NPOS:1];
    assign chk[k] = ^(plain & MASK);
  end

  always_comb begin
    logic [NPOS:1] h;
    h = plain;
    for (int k = 0; k < CHK_W; k++) h[1 << k] = chk[k];
    cw_o = {h, ^h};
  end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_ram_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = calc_chk_w(DATA_W),
  localparam int NPOS  = DATA_W + CHK_W,
  localparam int CW_W  = NPOS + 1
) (
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sec_o,
  output logic              ded_o
);
  logic [CHK_W-1:0] syn;
  logic             perr;
  logic             in_range;
  logic             do_fix;

  // syndrome = stored checks xor regenerated checks
  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    localparam logic [MAX_POS:0] FULL = cover_mask(NPOS, k);
    localparam logic [NPOS:1]    MASK = FULL[NPOS:1];
    assign syn[k] = ^(cw_i[NPOS:1] & MASK);
  end

  assign perr     = ^cw_i;
  assign in_range = (syn <= CHK_W'(NPOS));
  assign do_fix   = perr && (syn != '0) && in_range;

  // zero syndrome + parity error: parity bit itself flipped
  assign sec_o = perr && ((syn == '0) || in_range);
  assign ded_o = (syn != '0) && (!perr || !in_range);

  always_comb begin
    int di;
    di     = 0;
    data_o = '0;
    for (int p = 1; p <= NPOS; p++) begin
      if (!is_pow2(p)) begin
        data_o[di] = cw_i[p] ^ (do_fix && (syn == CHK_W'(p)));
        di++;
      end
    end
  end
endmodule

// File: rtl/ecc_err_cnt.sv
module ecc_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1 && !clr_i) |=> cnt_q == '1);

  a_r8_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/ecc_scrub.sv
module ecc_scrub #(
  parameter int ADDR_W = 9,
  parameter int CW_W   = 72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] hit_addr_i,
  input  logic [CW_W-1:0]   hit_cw_i,
  input  logic              usr_we_i,
  input  logic [ADDR_W-1:0] usr_addr_i,
  output logic              sc_we_o,
  output logic [ADDR_W-1:0] sc_addr_o,
  output logic [CW_W-1:0]   sc_cw_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [CW_W-1:0]   pend_cw_q;
  logic              drain, cancel, superseded, take;

  assign drain      = pend_q && !usr_we_i;
  assign cancel     = pend_q && usr_we_i && (usr_addr_i == pend_addr_q);
  // user write landing on the same edge already replaces the word
  assign superseded = usr_we_i && (usr_addr_i == hit_addr_i);
  assign take       = hit_i && !superseded && (!pend_q || drain || cancel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_cw_q   <= '0;
    end else if (take) begin
      pend_q      <= 1'b1;
      pend_addr_q <= hit_addr_i;
      pend_cw_q   <= hit_cw_i;
    end else if (drain || cancel) begin
      pend_q      <= 1'b0;
    end
  end

  assign sc_we_o   = drain;
  assign sc_addr_o = pend_addr_q;
  assign sc_cw_o   = pend_cw_q;

  a_r7_user_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && usr_we_i && usr_addr_i == pend_addr_q && !hit_i) |=> !pend_q);

  a_r7_other_write_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && usr_we_i && usr_addr_i != pend_addr_q) |=> (pend_q && $stable(pend_addr_q)));

  a_r6_drain_retires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_we_o && !hit_i) |=> !pend_q);
endmodule

// File: rtl/ecc_ram_scrub.sv
module ecc_ram_scrub
  import ecc_ram_pkg::*;
#(
  parameter int  DEPTH  = 512,
  parameter int  DATA_W = 64,
  parameter int  CNT_W  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CHK_W  = calc_chk_w(DATA_W),
  localparam int CW_W   = DATA_W + CHK_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CW_W-1:0]   wr_flip_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              scrub_en_i,
  input  logic              clr_sec_cnt_i,
  input  logic              clr_ded_cnt_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sec_o,
  output logic              ded_o,
  output logic [CNT_W-1:0]  sec_cnt_o,
  output logic [CNT_W-1:0]  ded_cnt_o
);
  logic [CW_W-1:0]   mem_q [DEPTH];
  logic [CW_W-1:0]   wr_cw, rd_cw_q, fix_cw, sc_cw;
  logic [ADDR_W-1:0] rd_addr_q, sc_addr;
  logic              rd_vld_q, sc_we, hit;
  logic [DATA_W-1:0] dec_data;
  logic              dec_sec, dec_ded;

  ecc_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc_wr (
    .data_i (wr_data_i),
    .cw_o   (wr_cw)
  );

  // user port first, scrub only on idle cycles
  always_ff @(posedge clk_i) begin
    if (wr_en_i)    mem_q[wr_addr_i] <= wr_cw ^ wr_flip_i;
    else if (sc_we) mem_q[sc_addr]   <= sc_cw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q  <= 1'b0;
      rd_addr_q <= '0;
      rd_cw_q   <= '0;
    end else begin
      rd_vld_q <= rd_en_i;
      if (rd_en_i) begin
        rd_addr_q <= rd_addr_i;
        rd_cw_q   <= mem_q[rd_addr_i];
      end
    end
  end

  ecc_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
    .cw_i   (rd_cw_q),
    .data_o (dec_data),
    .sec_o  (dec_sec),
    .ded_o  (dec_ded)
  );

  assign rd_valid_o = rd_vld_q;
  assign rd_data_o  = rd_vld_q ? dec_data : '0;
  assign sec_o      = rd_vld_q && dec_sec;
  assign ded_o      = rd_vld_q && dec_ded;

  // fresh check bits for the repaired payload
  ecc_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc_fix (
    .data_i (dec_data),
    .cw_o   (fix_cw)
  );

  assign hit = sec_o && scrub_en_i;

  ecc_scrub #(.ADDR_W(ADDR_W), .CW_W(CW_W)) u_scrub (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .hit_addr_i (rd_addr_q),
    .hit_cw_i   (fix_cw),
    .usr_we_i   (wr_en_i),
    .usr_addr_i (wr_addr_i),
    .sc_we_o    (sc_we),
    .sc_addr_o  (sc_addr),
    .sc_cw_o    (sc_cw)
  );

  ecc_err_cnt #(.CNT_W(CNT_W)) u_cnt_sec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (sec_o),
    .clr_i  (clr_sec_cnt_i),
    .cnt_o  (sec_cnt_o)
  );

  ecc_err_cnt #(.CNT_W(CNT_W)) u_cnt_ded (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ded_o),
    .clr_i  (clr_ded_cnt_i),
    .cnt_o  (ded_cnt_o)
  );

  a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  a_r3_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sec_o && ded_o));

  a_r8_sec_tracks_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o && !clr_sec_cnt_i && sec_cnt_o != '1) |=> sec_cnt_o == CNT_W'($past(sec_cnt_o) + 1'b1));

  a_r8_ded_tracks_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ded_o && !clr_ded_cnt_i && ded_cnt_o != '1) |=> ded_cnt_o == CNT_W'($past(ded_cnt_o) + 1'b1));

  a_r8_sec_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_o && !clr_sec_cnt_i) |=> $stable(sec_cnt_o));
endmodule

// File: tb/ecc_ram_scrub_tb.sv
`timescale 1ns/1ps
module ecc_ram_scrub_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [71:0] wr_flip = '0;
  logic        rd_en = 1'b0;
  logic [8:0]  rd_addr = '0;
  logic        scrub_en = 1'b0;
  logic        clr_sec = 1'b0;
  logic        clr_ded = 1'b0;
  logic        rd_valid_o, sec_o, ded_o;
  logic [63:0] rd_data_o;
  logic [15:0] sec_cnt_o, ded_cnt_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [63:0] data;
    bit          sec;
    bit          ded;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  ecc_ram_scrub u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .wr_en_i       (wr_en),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (wr_data),
    .wr_flip_i     (wr_flip),
    .rd_en_i       (rd_en),
    .rd_addr_i     (rd_addr),
    .scrub_en_i    (scrub_en),
    .clr_sec_cnt_i (clr_sec),
    .clr_ded_cnt_i (clr_ded),
    .rd_valid_o    (rd_valid_o),
    .rd_data_o     (rd_data_o),
    .sec_o         (sec_o),
    .ded_o         (ded_o),
    .sec_cnt_o     (sec_cnt_o),
    .ded_cnt_o     (ded_cnt_o)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(int a);
    logic [31:0] u;
    u = 32'(a) * 32'h9E37_79B1;
    return {u, (u ^ 32'hC3A5_5A3C) + 32'(a)};
  endfunction

  function automatic logic [71:0] bitm(int p);
    return 72'(1) << p;
  endfunction

  // data bit carried at codeword position p (R1 layout)
  function automatic logic [63:0] dbit(int p);
    int idx;
    if (p == 0 || (p & (p - 1)) == 0) return '0;
    idx = 0;
    for (int q = 1; q < p; q++) if ((q & (q - 1)) != 0) idx++;
    return 64'(1) << idx;
  endfunction

  task automatic wr(int a, logic [63:0] d, logic [71:0] f);
    wr_en = 1'b1; wr_addr = 9'(a); wr_data = d; wr_flip = f;
    @(negedge clk);
    wr_en = 1'b0; wr_flip = '0;
  endtask

  task automatic rd(int a, logic [63:0] d, bit s, bit dd, string tag);
    exp_t e;
    e.data = d; e.sec = s; e.ded = dd; e.tag = tag;
    sb_q.push_back(e);
    rd_en = 1'b1; rd_addr = 9'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R2 unexpected valid", 64'(rd_valid_o), 64'(0));
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rd_data_o == e.data, {e.tag, " data"}, rd_data_o, e.data);
        chk(sec_o == e.sec, {e.tag, " sec"}, 64'(sec_o), 64'(e.sec));
        chk(ded_o == e.ded, {e.tag, " ded"}, 64'(ded_o), 64'(e.ded));
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finish_run();
  end

  initial begin
    idle(3);
    // R10 reset state
    chk(rd_valid_o == 1'b0, "R10 valid", 64'(rd_valid_o), 0);
    chk(rd_data_o == '0, "R10 data", rd_data_o, 0);
    chk(!sec_o && !ded_o, "R10 flags", 64'({sec_o, ded_o}), 0);
    chk(sec_cnt_o == 0 && ded_cnt_o == 0, "R10 counters", 64'({sec_cnt_o, ded_cnt_o}), 0);
    rst_n = 1'b1;
    idle(1);

    // R2 clean path, edge addresses, back-to-back reads
    wr(0, pat(0), '0);
    wr(511, pat(511), '0);
    wr(5, '1, '0);
    wr(6, '0, '0);
    rd(0, pat(0), 0, 0, "R2");
    rd(511, pat(511), 0, 0, "R2");
    rd(5, '1, 0, 0, "R2");
    rd(6, '0, 0, 0, "R2");
    idle(2);
    chk(rd_valid_o == 1'b0 && rd_data_o == '0, "R2 idle", rd_data_o, 0);

    // R1 R3 R5 single flips at every position
    for (int p = 0; p < 72; p++) wr(100 + p, pat(p + 7), bitm(p));
    for (int p = 0; p < 72; p++)
      rd(100 + p, pat(p + 7), 1, 0, (p == 0) ? "R5" : "R1 R3");
    idle(3);
    chk(sec_cnt_o == 16'd72, "R8 sec count", 64'(sec_cnt_o), 72);
    chk(ded_cnt_o == 16'd0, "R8 ded untouched", 64'(ded_cnt_o), 0);

    // R4 double flips, data left uncorrected
    begin
      int pa [5] = '{1, 3, 0, 8, 70};
      int pb [5] = '{2, 71, 5, 64, 71};
      for (int i = 0; i < 5; i++) wr(200 + i, pat(i + 300), bitm(pa[i]) | bitm(pb[i]));
      for (int i = 0; i < 5; i++)
        rd(200 + i, pat(i + 300) ^ dbit(pa[i]) ^ dbit(pb[i]), 0, 1, "R4");
    end
    idle(3);
    chk(ded_cnt_o == 16'd5, "R8 ded count", 64'(ded_cnt_o), 5);
    chk(sec_cnt_o == 16'd72, "R8 sec untouched", 64'(sec_cnt_o), 72);

    // R9 clear
    clr_sec = 1'b1; idle(1); clr_sec = 1'b0;
    chk(sec_cnt_o == 16'd0, "R9 clear", 64'(sec_cnt_o), 0);
    chk(ded_cnt_o == 16'd5, "R9 other kept", 64'(ded_cnt_o), 5);
    rd(103, pat(10), 1, 0, "R9");
    clr_sec = 1'b1; idle(1); clr_sec = 1'b0;
    idle(2);
    chk(sec_cnt_o == 16'd0, "R9 clear beats increment", 64'(sec_cnt_o), 0);
    rd(103, pat(10), 1, 0, "R8");
    idle(2);
    chk(sec_cnt_o == 16'd1, "R8 single increment", 64'(sec_cnt_o), 1);

    // R6 scrub off keeps the error, scrub on clears it
    rd(104, pat(11), 1, 0, "R6 off");
    idle(4);
    rd(104, pat(11), 1, 0, "R6 off");
    idle(4);
    scrub_en = 1'b1;
    rd(104, pat(11), 1, 0, "R6");
    idle(4);
    rd(104, pat(11), 0, 0, "R6 scrubbed");
    rd(100, pat(7), 1, 0, "R5 R6");
    idle(4);
    rd(100, pat(7), 0, 0, "R5 R6 scrubbed");
    idle(2);

    // R7 same-address user write on the capture edge
    wr(302, pat(40), bitm(9));
    idle(2);
    rd(302, pat(40), 1, 0, "R7");
    wr(302, pat(41), '0);
    idle(4);
    rd(302, pat(41), 0, 0, "R7 capture superseded");
    // R7 same-address user write while pending
    wr(303, pat(42), bitm(33));
    idle(2);
    rd(303, pat(42), 1, 0, "R7");
    idle(1);
    wr(303, pat(43), '0);
    idle(4);
    rd(303, pat(43), 0, 0, "R7 pending cancelled");
    // R7 other-address write only delays
    wr(305, pat(44), bitm(50));
    wr(306, pat(45), '0);
    idle(2);
    rd(305, pat(44), 1, 0, "R7");
    idle(1);
    wr(306, pat(46), '0);
    idle(4);
    rd(305, pat(44), 0, 0, "R7 delayed scrub");
    rd(306, pat(46), 0, 0, "R7 other write");
    idle(2);

    // R8 saturation of the double-error counter
    scrub_en = 1'b0;
    clr_ded = 1'b1; idle(1); clr_ded = 1'b0;
    wr(400, pat(77), bitm(3) | bitm(5));
    for (int i = 0; i < 65540; i++)
      rd(400, pat(77) ^ 64'h3, 0, 1, "R4 R8");
    idle(3);
    chk(ded_cnt_o == 16'hFFFF, "R8 saturation", 64'(ded_cnt_o), 64'hFFFF);
    chk(sb_q.size() == 0, "R2 all reads answered", 64'(sb_q.size()), 0);
    finish_run();
  end
endmodule